// File: doc/BRIEF.md
# Receive Buffer with Fill Threshold and Idle Timeout

This block sits between a serial receiver and a host bus. It holds received characters in a small first-in first-out store. A data-ready flag tells the host that it is worth draining the store. The flag rises in two cases: when the number of held characters reaches a programmed level, or when the line has gone quiet while a partial batch is waiting. The second case lets the host collect the tail of a message that never reaches the level.

The receiver delivers a one-cycle strobe together with a 9-bit character and three error flags. The baud tick pulses once per bit period, and the line-idle input is high while the receive line rests. On the host side there is a read strobe, an 8-bit fill level, an idle-detect enable, set and clear pulses for the buffer enable, and a receive interrupt enable. Any character that arrives with an error switches the buffer off and flushes it, so the host has to re-enable it.

Top module: `rx_fill_buffer`

## Requirements
- R1: After reset, `buf_en`, `data_ready` and `rx_irq` are 0 and `host_rdata` is 0.
- R2: A `buf_en_set` pulse turns `buf_en` on from the next cycle, and a `buf_en_clr` pulse turns it off. While the buffer is off, all held characters are discarded and incoming strobes are ignored. A strobe in the same cycle as the set pulse is not stored.
- R3: Characters are returned in arrival order. The character appears on `host_rdata` in the cycle after the `host_rd` that takes it.
- R4: `data_ready` rises in the cycle after the write that brings the held count to `fill_level`+1 or more, so a level of 0 means one entry.
- R5: Once set, `data_ready` stays high until the buffer is empty, and it falls in the cycle after the read that empties it.
- R6: With `idle_det_en` high, at least one character held and the level not reached, `data_ready` rises after the 9th baud tick of an unbroken idle stretch (more than 8 ticks).
- R7: A host read that takes a character, a receive strobe, or `line_idle` going low during the idle count resets the count to zero, and counting starts again.
- R8: A strobe with any of `rx_perr`, `rx_ferr` or `rx_oerr` set clears `buf_en` in the next cycle. That character is not stored, and the held contents are flushed.
- R9: `rx_irq` is high exactly when `data_ready` and `rx_int_en` are both high.
- R10: A read from an empty buffer leaves `host_rdata` unchanged and takes nothing.
- R11: The buffer holds 16 characters. A strobe that arrives while 16 are held is dropped, and the held characters are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | One-cycle strobe marking a received character |
| rx_char | input | 9 | Received character |
| rx_perr | input | 1 | Parity error for the strobed character |
| rx_ferr | input | 1 | Framing error for the strobed character |
| rx_oerr | input | 1 | Overrun error for the strobed character |
| baud_tick | input | 1 | One pulse per bit period |
| line_idle | input | 1 | High while the receive line rests |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 9 | Last character read |
| fill_level | input | 8 | Ready level; the flag rises at fill_level+1 held entries |
| idle_det_en | input | 1 | Enables the idle timeout |
| buf_en_set | input | 1 | Pulse that turns the buffer on |
| buf_en_clr | input | 1 | Pulse that turns the buffer off |
| rx_int_en | input | 1 | Receive interrupt enable |
| buf_en | output | 1 | Buffer enable state |
| data_ready | output | 1 | Data-ready flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest case to reach is an idle count that is broken just before it expires. It takes a partial batch, a run of eight baud ticks on a quiet line, and then a read or a line pulse in exactly the right cycle. The stimulus holds `line_idle` high and spaces ticks a cycle apart. It inserts a read after a few ticks, then a short busy pulse, and finally lets a full stretch of nine ticks run. The behavioural model predicts the cycle in which the flag must rise, and it also predicts that the flag must not rise early.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
    typedef struct packed {
        logic parity;
        logic frame;
        logic overrun;
    } rx_err_t;

    function automatic logic err_any(input rx_err_t e);
        return e.parity | e.frame | e.overrun;
    endfunction
endpackage

// File: rtl/rxfb_store.sv
module rxfb_store #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rxfb_idle.sv
module rxfb_idle #(
    parameter int IDLE_TICKS = 8,
    localparam int CNTW      = $clog2(IDLE_TICKS + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic tick,
    output logic timeout
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = '0;
        timeout = 1'b0;
        if (arm) begin
            cnt_d   = cnt_q + CNTW'(tick);
            timeout = tick && (cnt_q == CNTW'(IDLE_TICKS));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt_q == '0)) else $error("idle count not cleared"); // R7
endmodule

// File: rtl/rx_fill_buffer.sv
module rx_fill_buffer #(
    parameter int DEPTH      = 16,
    parameter int W          = 9,
    parameter int LVL_W      = 8,
    parameter int IDLE_TICKS = 8,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = AW + 1,
    localparam int TW        = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_stb,
    input  logic [W-1:0]     rx_char,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    input  logic             rx_oerr,
    input  logic             baud_tick,
    input  logic             line_idle,
    input  logic             host_rd,
    output logic [W-1:0]     host_rdata,
    input  logic [LVL_W-1:0] fill_level,
    input  logic             idle_det_en,
    input  logic             buf_en_set,
    input  logic             buf_en_clr,
    input  logic             rx_int_en,
    output logic             buf_en,
    output logic             data_ready,
    output logic             rx_irq
);
    import rxfb_pkg::*;

    typedef struct packed {
        logic          en;
        logic          ready;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rd;
    } state_t;

    state_t d, q;
    rx_err_t err_s;
    logic err_evt, rd_ok, wr_ok, arm, timeout;
    logic [W-1:0]  mem_rdata;
    logic [TW-1:0] thr, cnt_ext;

    assign err_s   = '{parity: rx_perr, frame: rx_ferr, overrun: rx_oerr};
    assign err_evt = rx_stb && err_any(err_s);
    assign rd_ok   = q.en && host_rd && (q.cnt != '0);
    assign wr_ok   = q.en && rx_stb && !err_evt && (q.cnt < CW'(DEPTH));
    assign thr     = {1'b0, fill_level} + TW'(1);

    rxfb_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (q.wp),
        .wdata (rx_char),
        .raddr (q.rp),
        .rdata (mem_rdata)
    );

    rxfb_idle #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .tick    (baud_tick),
        .timeout (timeout)
    );

    always_comb begin
        d    = q;
        d.en = (q.en || buf_en_set) && !buf_en_clr && !err_evt;
        if (rd_ok) d.rd = mem_rdata;
        arm = d.en && q.en && idle_det_en && (q.cnt != '0) && !q.ready
              && line_idle && !rd_ok && !rx_stb;
        cnt_ext = '0;
        if (!d.en) begin
            d.wp    = '0;
            d.rp    = '0;
            d.cnt   = '0;
            d.ready = 1'b0;
        end else begin
            if (wr_ok) d.wp = q.wp + AW'(1);
            if (rd_ok) d.rp = q.rp + AW'(1);
            d.cnt   = q.cnt + CW'(wr_ok) - CW'(rd_ok);
            cnt_ext = TW'(d.cnt);
            if (d.cnt == '0)          d.ready = 1'b0;
            else if (cnt_ext >= thr)  d.ready = 1'b1;
            else if (timeout)         d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign host_rdata = q.rd;
    assign buf_en     = q.en;
    assign data_ready = q.ready;
    assign rx_irq     = q.ready && rx_int_en;

    AST_READY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        q.ready |-> (q.cnt != '0)) else $error("ready with empty store"); // R5
    AST_OFF_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |-> (q.cnt == '0 && !q.ready)) else $error("disabled but holding"); // R2
    AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && (rx_perr || rx_ferr || rx_oerr)) |=> !buf_en) else $error("error kept enable"); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)) else $error("count above depth"); // R11
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && q.cnt == '0) |=> $stable(host_rdata)) else $error("empty read changed data"); // R10
endmodule

// File: tb/sim_rx_fill_buffer.sv
module sim_rx_fill_buffer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_stb = 0, rx_perr = 0, rx_ferr = 0, rx_oerr = 0;
    logic [8:0] rx_char = '0;
    logic baud_tick = 0, line_idle = 0, host_rd = 0;
    logic [7:0] fill_level = '0;
    logic idle_det_en = 0, buf_en_set = 0, buf_en_clr = 0, rx_int_en = 0;
    logic [8:0] host_rdata;
    logic buf_en, data_ready, rx_irq;

    int errors = 0, checks = 0, cycles = 0;
    string tag = "R1";

    logic [8:0] mq[$];
    logic m_en = 0, m_ready = 0;
    logic [8:0] m_rd = '0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    rx_fill_buffer u0 (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_char(rx_char),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr),
        .baud_tick(baud_tick), .line_idle(line_idle), .host_rd(host_rd),
        .host_rdata(host_rdata), .fill_level(fill_level), .idle_det_en(idle_det_en),
        .buf_en_set(buf_en_set), .buf_en_clr(buf_en_clr), .rx_int_en(rx_int_en),
        .buf_en(buf_en), .data_ready(data_ready), .rx_irq(rx_irq)
    );

    task automatic model_step();
        logic err, rdok, en_n, cond, tmo, full;
        int cnt_n;
        err  = rx_stb && (rx_perr || rx_ferr || rx_oerr);
        rdok = m_en && host_rd && mq.size() > 0;
        en_n = (m_en || buf_en_set) && !buf_en_clr && !err;
        cond = en_n && m_en && idle_det_en && mq.size() != 0 && !m_ready
               && line_idle && !rdok && !rx_stb;
        tmo   = cond && baud_tick && m_cnt == 8;
        cnt_n = cond ? m_cnt + int'(baud_tick) : 0;
        full  = mq.size() >= 16;
        if (rdok) m_rd = mq.pop_front();
        if (!en_n) begin
            mq.delete();
            m_ready = 0;
            m_cnt = 0;
        end else begin
            if (m_en && rx_stb && !err && !full) mq.push_back(rx_char);
            if (mq.size() == 0) m_ready = 0;
            else if (mq.size() >= int'(fill_level) + 1) m_ready = 1;
            else if (tmo) m_ready = 1;
            m_cnt = cnt_n;
        end
        m_en = en_n;
    endtask

    task automatic compare();
        logic exp_irq;
        exp_irq = m_ready && rx_int_en;
        checks++;
        if (buf_en !== m_en || data_ready !== m_ready || rx_irq !== exp_irq
            || host_rdata !== m_rd) begin
            errors++;
            $display("FAIL %s: en=%0b ready=%0b irq=%0b data=%h expected en=%0b ready=%0b irq=%0b data=%h",
                     tag, buf_en, data_ready, rx_irq, host_rdata, m_en, m_ready, exp_irq, m_rd);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic push(input logic [8:0] c);
        rx_stb = 1; rx_char = c; cyc(); rx_stb = 0;
    endtask

    task automatic pull();
        host_rd = 1; cyc(); host_rd = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1; cyc(); baud_tick = 0; cyc();
        end
    endtask

    task automatic enable();
        buf_en_set = 1; cyc(); buf_en_set = 0;
    endtask

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        tag = "R1";
        compare();
        idle(2);

        tag = "R2";
        buf_en_set = 1; rx_stb = 1; rx_char = 9'h0AA; cyc();
        buf_en_set = 0; rx_stb = 0;
        idle(1);

        tag = "R4"; rx_int_en = 1; fill_level = 8'd3;
        push(9'h101); idle(1); push(9'h002); push(9'h003); idle(2); push(9'h104); idle(2);
        tag = "R3"; pull(); pull(); idle(1);
        tag = "R5"; pull(); idle(1); pull(); idle(2);
        tag = "R10"; pull(); pull(); idle(1);

        tag = "R4"; fill_level = 8'd0; push(9'h055); idle(1); pull(); idle(1);

        tag = "R9"; fill_level = 8'd1; rx_int_en = 0; push(9'h011); push(9'h012); idle(1);
        rx_int_en = 1; idle(1); pull(); pull(); idle(1);

        tag = "R6"; fill_level = 8'd5; idle_det_en = 1;
        push(9'h0C1); push(9'h0C2); line_idle = 1; ticks(12); pull(); pull(); idle(1);

        tag = "R7"; line_idle = 0;
        push(9'h0D1); push(9'h0D2); line_idle = 1; ticks(5); pull(); ticks(6);
        line_idle = 0; cyc(); line_idle = 1; ticks(7);
        push(9'h0D3); ticks(10); pull(); pull(); idle(1);
        idle_det_en = 0; line_idle = 0;

        tag = "R11"; fill_level = 8'd200;
        for (int i = 0; i < 18; i++) push(9'(i + 9'h040));
        idle(1);
        for (int i = 0; i < 17; i++) pull();
        idle(1);

        tag = "R2"; fill_level = 8'd1;
        push(9'h071); push(9'h072); idle(1);
        buf_en_clr = 1; cyc(); buf_en_clr = 0;
        push(9'h073); pull(); idle(1);
        enable(); idle(1); pull(); push(9'h074); pull(); idle(1);

        tag = "R8";
        push(9'h081); push(9'h082);
        rx_perr = 1; push(9'h083); rx_perr = 0; idle(1);
        enable(); pull(); idle(1);
        push(9'h084); rx_ferr = 1; push(9'h085); rx_ferr = 0;
        enable(); push(9'h086); rx_oerr = 1; push(9'h087); rx_oerr = 0;
        enable(); idle(1); pull(); idle(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule